// File: doc/BRIEF.md
# Multiplexed Display Latch Sequencer

This block listens to two 8-bit output ports of a parallel interface that feeds a bank of multiplexed seven-segment score displays. One port carries a one-hot column strobe, the other carries a BCD digit in its upper nibble. An active-low enable line frames each refresh burst.

While the enable line is low, the block tracks the active digit column and counts port writes. The running count decides which of five display banks receives the current nibble. The nibble is decoded to a seven-segment pattern and stored in a 5 x 6 register file. Any stored pattern can be read back combinationally through an indexed port.

A second, independent control line drives a status indicator whose level is the inverse of that line.

Top module: `display_latch_seq`

## Requirements
- R1: While `enable_n` is high, the write counter is held at zero, and writes to either port leave the digit index, the latched nibble and every segment register unchanged.
- R2: On a processed strobe write, the digit index is chosen by priority: bit 2 gives digit 5, bit 3 digit 4, bit 4 digit 3, bit 5 digit 2, bit 6 digit 1 and bit 7 digit 0. The lowest set bit among bits 2..7 wins.
- R3: A processed strobe write with bits 2..7 all clear keeps the previous digit index.
- R4: Each processed write to either port adds one to a shared counter. When both ports are written in the same cycle, the strobe write is applied first (new digit and one increment), and then the data write (a second increment).
- R5: On a processed data write, let c be the counter value just before that write's own increment. If c equals 3, the nibble latched before this write is stored in bank 0 at the current digit. The new upper nibble `data_port[7:4]` then becomes the latched nibble.
- R6: After the data write's increment, a counter value of 4, 6, 8 or 10 stores the newly latched nibble in bank 1, 2, 3 or 4 respectively, at the current digit.
- R7: Digits 0..9 decode to the segment patterns 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex, with bit 0 as segment a). Codes 10..15 decode to 00.
- R8: The counter saturates at 15, so a long burst cannot write any bank again.
- R9: After reset, every segment register is 00, and the digit index, latched nibble and counter are zero.
- R10: `rd_seg` returns the pattern at (`rd_bank`, `rd_digit`) in the same cycle. An index outside 0..4 or 0..5 returns 00.
- R11: `ind_out` is always the inverse of `ind_ctl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_n | input | 1 | Active-low burst enable; high clears the counter |
| strobe_we | input | 1 | Write pulse for the strobe port |
| strobe_data | input | 8 | One-hot column strobe byte |
| data_we | input | 1 | Write pulse for the data port |
| data_port | input | 8 | Data byte; the upper nibble is BCD |
| ind_ctl | input | 1 | Indicator control line |
| ind_out | output | 1 | Indicator, inverse of `ind_ctl` |
| rd_bank | input | 3 | Read-back bank index |
| rd_digit | input | 3 | Read-back digit index |
| rd_seg | output | 7 | Read-back segment pattern |

## Verification
A column change and a bank store can fall in the same cycle, when a strobe write and a data write arrive together. The strobe's increment can then carry the counter onto 3, so that the bank 0 store lands at the freshly selected digit and uses the old nibble. The bank 1 store in that same cycle takes the new nibble. The bench sets the counter to 2, issues both writes on one edge, and reads back both banks at the new and the old digit. It then compares the results against patterns worked out from the ordering rule.

// File: rtl/display_latch_seq.sv
module display_latch_seq #(
  parameter int NBANK = 5,
  parameter int NDIG  = 6,
  parameter int CW    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable_n,
  input  logic       strobe_we,
  input  logic [7:0] strobe_data,
  input  logic       data_we,
  input  logic [7:0] data_port,
  input  logic       ind_ctl,
  output logic       ind_out,
  input  logic [2:0] rd_bank,
  input  logic [2:0] rd_digit,
  output logic [6:0] rd_seg
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [6:0]    segs [NBANK][NDIG];
  logic [CW-1:0] cnt;
  logic [2:0]    digit;
  logic [3:0]    nib;

  logic          act_s, act_d;
  logic [2:0]    digit_nx;
  logic [CW-1:0] cnt_mid, cnt_post;

  function automatic logic [6:0] bcd7(input logic [3:0] v);
    case (v)
      4'd0: bcd7 = 7'h3F;  4'd1: bcd7 = 7'h06;
      4'd2: bcd7 = 7'h5B;  4'd3: bcd7 = 7'h4F;
      4'd4: bcd7 = 7'h66;  4'd5: bcd7 = 7'h6D;
      4'd6: bcd7 = 7'h7D;  4'd7: bcd7 = 7'h07;
      4'd8: bcd7 = 7'h7F;  4'd9: bcd7 = 7'h6F;
      default: bcd7 = 7'h00;
    endcase
  endfunction

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] c);
    sat_inc = (c == CMAX) ? CMAX : c + 1'b1;
  endfunction

  assign act_s = strobe_we && !enable_n;
  assign act_d = data_we && !enable_n;
  assign ind_out = ~ind_ctl;

  always_comb begin
    digit_nx = digit;
    if (act_s)
      for (int i = 7; i >= 2; i--)
        if (strobe_data[i]) digit_nx = 3'(7 - i);
  end

  assign cnt_mid  = act_s ? sat_inc(cnt) : cnt;
  assign cnt_post = sat_inc(cnt_mid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      digit <= '0;
      nib   <= '0;
      for (int b = 0; b < NBANK; b++)
        for (int d = 0; d < NDIG; d++)
          segs[b][d] <= '0;
    end else if (enable_n) begin
      cnt <= '0;
    end else begin
      digit <= digit_nx;
      if (act_d) begin
        cnt <= cnt_post;
        nib <= data_port[7:4];
        if (cnt_mid == CW'(3))
          segs[0][digit_nx] <= bcd7(nib);
        for (int b = 1; b < NBANK; b++)
          if (cnt_post == CW'(2 + 2 * b))
            segs[b][digit_nx] <= bcd7(data_port[7:4]);
      end else begin
        cnt <= cnt_mid;
      end
    end
  end

  assign rd_seg = (int'(rd_bank) < NBANK && int'(rd_digit) < NDIG)
                  ? segs[rd_bank][rd_digit] : 7'h00;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    enable_n |=> (cnt == '0) && $stable(digit) && $stable(nib));
  assert_keep_digit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_n && strobe_we && strobe_data[7:2] == 6'd0) |=> $stable(digit));
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_n && data_we && !strobe_we && cnt != CMAX) |=> cnt == $past(cnt) + 1'b1);
  assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_n && cnt == CMAX) |=> cnt == CMAX);
  assert_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_n && data_we) |=> nib == $past(data_port[7:4]));
endmodule

// File: tb/display_latch_seq_bench.sv
`timescale 1ns/1ps
module display_latch_seq_bench;
  logic clk = 0, rst_n = 0, enable_n = 1, strobe_we = 0, data_we = 0, ind_ctl = 0;
  logic [7:0] strobe_data = 0, data_port = 0;
  logic [2:0] rd_bank = 0, rd_digit = 0;
  logic ind_out;
  logic [6:0] rd_seg;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  display_latch_seq u_display_latch_seq (.*);

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input int b, input int d, input logic [6:0] exp);
    rd_bank = 3'(b); rd_digit = 3'(d); #1;
    chk(req, rd_seg, exp);
  endtask

  task automatic wr(input logic s, input logic [7:0] sv, input logic d, input logic [7:0] dv);
    @(negedge clk);
    strobe_we = s; strobe_data = sv; data_we = d; data_port = dv;
    @(negedge clk);
    strobe_we = 0; data_we = 0;
  endtask

  task automatic restart();
    @(negedge clk); enable_n = 1;
    @(negedge clk); enable_n = 0;
  endtask

  task automatic t_reset();
    for (int b = 0; b < 5; b++)
      for (int d = 0; d < 6; d++)
        rd("R9", b, d, 7'h00);
  endtask

  task automatic t_banks();
    restart();
    wr(1, 8'h04, 0, 0);
    for (int n = 1; n <= 9; n++) wr(0, 0, 1, 8'(n << 4));
    rd("R5", 0, 5, 7'h5B);
    rd("R6", 1, 5, 7'h4F);
    rd("R6", 2, 5, 7'h6D);
    rd("R6", 3, 5, 7'h07);
    rd("R6 R7", 4, 5, 7'h6F);
    rd("R2", 0, 0, 7'h00);
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 24; k++) wr(0, 0, 1, 8'h10);
    rd("R8", 1, 5, 7'h4F);
    rd("R8", 0, 5, 7'h5B);
  endtask

  task automatic t_ignore_keep();
    @(negedge clk); enable_n = 1;
    wr(1, 8'h80, 1, 8'h70);
    wr(0, 0, 1, 8'h30);
    rd("R1", 0, 0, 7'h00);
    @(negedge clk); enable_n = 0;
    wr(1, 8'h00, 0, 0);
    wr(0, 0, 1, 8'h80);
    wr(0, 0, 1, 8'hB0);
    wr(0, 0, 1, 8'h00);
    rd("R3 R7", 0, 5, 7'h00);
    rd("R3", 1, 5, 7'h3F);
    rd("R1", 0, 0, 7'h00);
  endtask

  task automatic t_same_cycle();
    restart();
    wr(0, 0, 1, 8'h40);
    wr(0, 0, 1, 8'h10);
    wr(1, 8'h88, 1, 8'h20);
    rd("R4 R2", 0, 4, 7'h06);
    rd("R4", 1, 4, 7'h5B);
    rd("R4", 0, 5, 7'h00);
    rd("R4", 1, 5, 7'h3F);
  endtask

  task automatic t_misc();
    rd("R10", 5, 0, 7'h00);
    rd("R10", 1, 6, 7'h00);
    ind_ctl = 0; #1; chk("R11", {6'd0, ind_out}, 7'd1);
    ind_ctl = 1; #1; chk("R11", {6'd0, ind_out}, 7'd0);
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_banks();
    t_saturate();
    t_ignore_keep();
    t_same_cycle();
    t_misc();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule